// File: doc/BRIEF.md
# Delayed-Branch Fetch Address Sequencer

This block decides where instruction fetch goes next for a 16-bit instruction stream with delayed control transfers. Each time an instruction is issued, it takes the instruction word, the address of that instruction, the T condition flag, the value of the register named in the instruction and the current procedure register. From these it produces the next fetch address in the same cycle. The procedure register is external. When a call executes, the block gives a write strobe and a return address for it.

Conditional branches test T. PC-relative branches add a scaled, sign-extended displacement to the instruction address plus four. Register-relative branches add the register value to that same base. Absolute jumps load the register value, and the return instruction loads the procedure register. Every unconditional transfer is delayed: the instruction that follows it executes first, and only then does fetch move to the target. The conditional branches have a delayed form and a non-delayed form. The block stores the pending target across the slot and marks the slot instruction. If a transfer is issued inside a slot, the block flags it as illegal and does not act on it.

Top module: `dbr_pc_seq`

## Requirements
- R1: While reset is held, and after it is released, no slot is pending: `in_slot_o` is 0, and an issued non-transfer instruction gives `next_pc_o` = `pc_i`+2 with `pr_we_o` and `slot_illegal_o` at 0.
- R2: A non-delayed conditional branch is taken when T matches its sense: pattern 10001001 + 8-bit d needs T=1, and pattern 10001011 + d needs T=0. When taken, `next_pc_o` = `pc_i`+4+2·sext(d) in the same cycle, and no slot follows.
- R3: A conditional branch that is not taken, in either its delayed or non-delayed form, gives `next_pc_o` = `pc_i`+2 and opens no slot.
- R4: A taken delayed conditional branch (10001101 + d needs T=1, 10001111 + d needs T=0) gives `next_pc_o` = `pc_i`+2. The next issued instruction then has `in_slot_o`=1, and its `next_pc_o` is the branch target.
- R5: The unconditional branch (prefix 1010) and the call (prefix 1011) use a 12-bit displacement in bits 11:0. It is sign-extended and doubled, and both forms are delayed.
- R6: Calls (prefix 1011, 0000nnnn00000011, 0100nnnn00001011) assert `pr_we_o` with `pr_wdata_o` = `pc_i`+4 in their issue cycle. No other instruction asserts `pr_we_o`.
- R7: The register-relative branch 0000nnnn00100011 and call 0000nnnn00000011 target `pc_i`+4+`rn_i` and are delayed.
- R8: The jump 0100nnnn00101011 and jump-to-subroutine 0100nnnn00001011 target `rn_i`. The return 0000000000001011 targets `pr_i`. All three are delayed.
- R9: A transfer instruction issued in a slot raises `slot_illegal_o` and writes no PR. Its `next_pc_o` is the already pending target. The slot then closes.
- R10: In a cycle with `issue_i`=0, `next_pc_o` = `pc_i`, there is no PR write and no flag, and a pending slot stays pending.
- R11: A non-transfer instruction in a slot gives `next_pc_o` = the pending target with `slot_illegal_o`=0, and the slot then closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | An instruction executes this cycle |
| pc_i | input | ADDR_W | Address of the issued instruction |
| insn_i | input | 16 | Issued instruction word |
| t_i | input | 1 | T condition flag |
| rn_i | input | ADDR_W | Value of the register selected by bits 11:8 |
| pr_i | input | ADDR_W | Current procedure register value |
| next_pc_o | output | ADDR_W | Next fetch address |
| pr_we_o | output | 1 | Procedure register write strobe |
| pr_wdata_o | output | ADDR_W | Return address to write to PR |
| in_slot_o | output | 1 | The issued instruction is a delay slot |
| slot_illegal_o | output | 1 | A transfer was issued inside a delay slot |

## Verification
The next address, the PR write and the illegal flag depend only on the current inputs and the slot state, so each one is due in the same cycle its instruction is issued. The slot indicator and the slot target are due one issue later. The bench drives every input just after a falling edge and compares all outputs a short time later, before the next rising edge. A behavioural model holds a pending flag and a target, and updates them only at the point that matches the rising edge. Idle cycles are compared in the same way, which checks that a pending slot survives gaps in issue.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

   // where a control transfer takes its destination from
   typedef enum logic [2:0] {
      SRC_DISP8  = 3'd0,   // seq base + 2*sext(8-bit)
      SRC_DISP12 = 3'd1,   // seq base + 2*sext(12-bit)
      SRC_RN_REL = 3'd2,   // seq base + register
      SRC_RN_ABS = 3'd3,   // register value
      SRC_PR     = 3'd4    // procedure register
   } tgt_src_e;

   typedef struct packed {
      logic     is_xfer;      // any branch, jump, call or return
      logic     conditional;  // depends on T
      logic     sense;        // T value that makes it taken
      logic     delayed;      // following instruction runs first
      logic     link;         // writes return address
      tgt_src_e src;
   } xfer_dec_t;

   localparam int unsigned INSN_BITS   = 16;
   localparam int unsigned SEQ_STEP    = 2;
   localparam int unsigned LINK_OFFSET = 4;

endpackage

// File: rtl/dbr_decode.sv
module dbr_decode
   import dbr_pkg::*;
#(
   parameter int unsigned INSN_W = 16
) (
   input  logic [INSN_W-1:0] insn,
   output xfer_dec_t         dec
);

   localparam int unsigned OP_HI = INSN_W - 1;
   localparam int unsigned OP_LO = INSN_W - 4;

   logic [3:0] major;
   logic [7:0] upper;
   logic [7:0] lower;

   assign major = insn[OP_HI:OP_LO];
   assign upper = insn[OP_HI:OP_HI-7];
   assign lower = insn[7:0];

   always_comb begin
      dec = '{is_xfer: 1'b0, conditional: 1'b0, sense: 1'b0,
              delayed: 1'b0, link: 1'b0, src: SRC_DISP8};
      unique case (major)
         4'h8: begin
            // conditional family: 8'h89 / 8'h8B plain, 8'h8D / 8'h8F delayed
            if (upper[3:0] == 4'h9 || upper[3:0] == 4'hB ||
                upper[3:0] == 4'hD || upper[3:0] == 4'hF) begin
               dec.is_xfer     = 1'b1;
               dec.conditional = 1'b1;
               dec.sense       = ~upper[1];
               dec.delayed     = upper[2];
               dec.src         = SRC_DISP8;
            end
         end
         4'hA, 4'hB: begin
            dec.is_xfer = 1'b1;
            dec.delayed = 1'b1;
            dec.link    = major[0];
            dec.src     = SRC_DISP12;
         end
         4'h0: begin
            if (lower == 8'h23 || lower == 8'h03) begin
               dec.is_xfer = 1'b1;
               dec.delayed = 1'b1;
               dec.link    = (lower == 8'h03);
               dec.src     = SRC_RN_REL;
            end else if (insn[OP_HI-4:8] == 4'h0 && lower == 8'h0B) begin
               dec.is_xfer = 1'b1;
               dec.delayed = 1'b1;
               dec.src     = SRC_PR;
            end
         end
         4'h4: begin
            if (lower == 8'h2B || lower == 8'h0B) begin
               dec.is_xfer = 1'b1;
               dec.delayed = 1'b1;
               dec.link    = (lower == 8'h0B);
               dec.src     = SRC_RN_ABS;
            end
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/dbr_target.sv
module dbr_target
   import dbr_pkg::*;
#(
   parameter int unsigned ADDR_W       = 32,
   parameter bit          SHARED_ADDER = 1'b1
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic [11:0]       disp,
   input  logic [ADDR_W-1:0] rn,
   input  logic [ADDR_W-1:0] pr,
   input  tgt_src_e          src,
   output logic [ADDR_W-1:0] seq_base,
   output logic [ADDR_W-1:0] target
);

   localparam int unsigned EXT8  = ADDR_W - 9;
   localparam int unsigned EXT12 = ADDR_W - 13;

   logic [ADDR_W-1:0] off8;
   logic [ADDR_W-1:0] off12;
   logic [ADDR_W-1:0] rel_sum;

   assign seq_base = pc + ADDR_W'(LINK_OFFSET);
   assign off8     = {{EXT8{disp[7]}},   disp[7:0],  1'b0};
   assign off12    = {{EXT12{disp[11]}}, disp[11:0], 1'b0};

   generate
      if (SHARED_ADDER) begin : g_shared
         logic [ADDR_W-1:0] off_sel;
         always_comb begin
            unique case (src)
               SRC_DISP8:  off_sel = off8;
               SRC_DISP12: off_sel = off12;
               default:    off_sel = rn;
            endcase
         end
         assign rel_sum = seq_base + off_sel;
      end else begin : g_parallel
         logic [ADDR_W-1:0] sum8;
         logic [ADDR_W-1:0] sum12;
         logic [ADDR_W-1:0] sumrn;
         assign sum8  = seq_base + off8;
         assign sum12 = seq_base + off12;
         assign sumrn = seq_base + rn;
         always_comb begin
            unique case (src)
               SRC_DISP8:  rel_sum = sum8;
               SRC_DISP12: rel_sum = sum12;
               default:    rel_sum = sumrn;
            endcase
         end
      end
   endgenerate

   always_comb begin
      unique case (src)
         SRC_RN_ABS: target = rn;
         SRC_PR:     target = pr;
         default:    target = rel_sum;
      endcase
   end

endmodule

// File: rtl/dbr_slot_track.sv
module dbr_slot_track #(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic              launch,
   input  logic [ADDR_W-1:0] launch_tgt,
   output logic              pending,
   output logic [ADDR_W-1:0] pend_tgt
);

   logic              pend_q;
   logic [ADDR_W-1:0] tgt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         tgt_q  <= '0;
      end else if (issue) begin
         pend_q <= launch;
         if (launch) tgt_q <= launch_tgt;
      end
   end

   assign pending  = pend_q;
   assign pend_tgt = tgt_q;

endmodule

// File: rtl/dbr_pc_seq.sv
module dbr_pc_seq
   import dbr_pkg::*;
#(
   parameter int unsigned ADDR_W       = 32,
   parameter int unsigned INSN_W       = 16,
   parameter bit          SHARED_ADDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [INSN_W-1:0] insn_i,
   input  logic              t_i,
   input  logic [ADDR_W-1:0] rn_i,
   input  logic [ADDR_W-1:0] pr_i,
   output logic [ADDR_W-1:0] next_pc_o,
   output logic              pr_we_o,
   output logic [ADDR_W-1:0] pr_wdata_o,
   output logic              in_slot_o,
   output logic              slot_illegal_o
);

   generate
      if (INSN_W != INSN_BITS) begin : g_bad_insn
         $error("dbr_pc_seq: INSN_W must be 16");
      end
      if (ADDR_W < 16) begin : g_bad_addr
         $error("dbr_pc_seq: ADDR_W must be at least 16");
      end
   endgenerate

   xfer_dec_t         dec;
   logic [ADDR_W-1:0] seq_base;
   logic [ADDR_W-1:0] target;
   logic              pending;
   logic [ADDR_W-1:0] pend_tgt;
   logic              taken;
   logic              launch;

   dbr_decode #(.INSN_W(INSN_W)) u_dec (
      .insn (insn_i),
      .dec  (dec)
   );

   dbr_target #(.ADDR_W(ADDR_W), .SHARED_ADDER(SHARED_ADDER)) u_tgt (
      .pc       (pc_i),
      .disp     (insn_i[11:0]),
      .rn       (rn_i),
      .pr       (pr_i),
      .src      (dec.src),
      .seq_base (seq_base),
      .target   (target)
   );

   assign taken  = dec.is_xfer && (!dec.conditional || (t_i == dec.sense));
   assign launch = issue_i && !pending && taken && dec.delayed;

   dbr_slot_track #(.ADDR_W(ADDR_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .issue      (issue_i),
      .launch     (launch),
      .launch_tgt (target),
      .pending    (pending),
      .pend_tgt   (pend_tgt)
   );

   always_comb begin
      next_pc_o      = pc_i;
      pr_we_o        = 1'b0;
      slot_illegal_o = 1'b0;
      if (issue_i) begin
         if (pending) begin
            next_pc_o      = pend_tgt;
            slot_illegal_o = dec.is_xfer;
         end else if (taken && !dec.delayed) begin
            next_pc_o = target;
         end else begin
            next_pc_o = pc_i + ADDR_W'(SEQ_STEP);
            pr_we_o   = taken && dec.link;
         end
      end
   end

   assign pr_wdata_o = seq_base;
   assign in_slot_o  = pending;

endmodule

// File: rtl/dbr_pc_seq_chk.sv
module dbr_pc_seq_chk #(
   parameter int unsigned ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              issue_i,
   input logic [ADDR_W-1:0] pc_i,
   input logic              pr_we_o,
   input logic [ADDR_W-1:0] pr_wdata_o,
   input logic              in_slot_o,
   input logic              slot_illegal_o
);

   a_r6_link_value: assert property (@(posedge clk) disable iff (!rst_n)
      pr_we_o |-> (pr_wdata_o == pc_i + ADDR_W'(4)));

   a_r6_link_needs_issue: assert property (@(posedge clk) disable iff (!rst_n)
      pr_we_o |-> issue_i);

   a_r4_call_opens_slot: assert property (@(posedge clk) disable iff (!rst_n)
      pr_we_o |=> in_slot_o);

   a_r9_slot_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && in_slot_o) |=> !in_slot_o);

   a_r9_illegal_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
      slot_illegal_o |-> (in_slot_o && issue_i && !pr_we_o));

   a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_i |=> $stable(in_slot_o));

endmodule

bind dbr_pc_seq dbr_pc_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .issue_i        (issue_i),
   .pc_i           (pc_i),
   .pr_we_o        (pr_we_o),
   .pr_wdata_o     (pr_wdata_o),
   .in_slot_o      (in_slot_o),
   .slot_illegal_o (slot_illegal_o)
);

// File: tb/tb_dbr_pc_seq.sv
module tb_dbr_pc_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue_i = 1'b0;
   logic [31:0] pc_i = '0;
   logic [15:0] insn_i = '0;
   logic        t_i = 1'b0;
   logic [31:0] rn_i = '0;
   logic [31:0] pr_i = '0;
   logic [31:0] next_pc_o;
   logic        pr_we_o;
   logic [31:0] pr_wdata_o;
   logic        in_slot_o;
   logic        slot_illegal_o;

   int vectors = 0;
   int miscompares = 0;

   // reference state
   bit          m_pend = 0;
   logic [31:0] m_tgt = '0;

   always #2 clk = ~clk;

   dbr_pc_seq dut (.*);

   task automatic report(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // one cycle: drive, compare against model, advance model at the edge
   task automatic step(input string req, input bit iss, input logic [31:0] pc,
                       input logic [15:0] ins, input bit t,
                       input logic [31:0] rn, input logic [31:0] pr);
      bit          xfer, delayed, link, tk;
      logic [31:0] tgt, e_next;
      bit          e_we, e_ill;
      int          d;
      @(negedge clk);
      issue_i = iss; pc_i = pc; insn_i = ins; t_i = t; rn_i = rn; pr_i = pr;
      #1;
      xfer = 0; delayed = 1; link = 0; tk = 1; tgt = '0;
      casez (ins)
         16'b1000_1001_????_????: begin xfer = 1; delayed = 0; tk = t;  end
         16'b1000_1011_????_????: begin xfer = 1; delayed = 0; tk = !t; end
         16'b1000_1101_????_????: begin xfer = 1; tk = t;  end
         16'b1000_1111_????_????: begin xfer = 1; tk = !t; end
         16'b1010_????_????_????: xfer = 1;
         16'b1011_????_????_????: begin xfer = 1; link = 1; end
         16'b0000_????_0010_0011: xfer = 1;
         16'b0000_????_0000_0011: begin xfer = 1; link = 1; end
         16'b0100_????_0010_1011: xfer = 1;
         16'b0100_????_0000_1011: begin xfer = 1; link = 1; end
         16'b0000_0000_0000_1011: xfer = 1;
         default: ;
      endcase
      if (ins[15:12] == 4'h8) begin
         d = int'($signed(ins[7:0]));
         tgt = pc + 32'd4 + 32'(d * 2);
      end else if (ins[15:13] == 3'b101) begin
         d = int'($signed(ins[11:0]));
         tgt = pc + 32'd4 + 32'(d * 2);
      end else if (ins[15:12] == 4'h0 && ins[7:0] == 8'h0B) tgt = pr;
      else if (ins[15:12] == 4'h0) tgt = pc + 32'd4 + rn;
      else tgt = rn;
      tk = xfer && tk;
      e_we = 0; e_ill = 0;
      if (!iss) e_next = pc;
      else if (m_pend) begin e_next = m_tgt; e_ill = xfer; end
      else if (tk && !delayed) e_next = tgt;
      else begin e_next = pc + 32'd2; e_we = tk && link; end
      vectors++;
      report(req, "in_slot", 32'(in_slot_o), 32'(m_pend));
      report(req, "next_pc", next_pc_o, e_next);
      report(req, "pr_we", 32'(pr_we_o), 32'(e_we));
      report(req, "illegal", 32'(slot_illegal_o), 32'(e_ill));
      if (e_we) report(req, "pr_wdata", pr_wdata_o, pc + 32'd4);
      if (iss) begin
         if (m_pend) m_pend = 0;
         else if (tk && delayed) begin m_pend = 1; m_tgt = tgt; end
      end
   endtask

   initial begin
      #190000;
      miscompares++;
      $display("FAIL watchdog expired actual=%0d expected=done", vectors);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   localparam logic [15:0] NOP = 16'h0009;

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      #1;
      vectors++;
      report("R1", "in_slot_rst", 32'(in_slot_o), 32'd0);
      @(negedge clk); rst_n = 1'b1;
      step("R1", 1, 32'h0000_0100, NOP, 0, 0, 0);
      // R2 / R3 plain conditionals
      step("R2", 1, 32'h0000_1000, 16'h8905, 1, 0, 0);
      step("R3", 1, 32'h0000_1000, 16'h8905, 0, 0, 0);
      step("R2", 1, 32'h0000_2000, 16'h8BFE, 0, 0, 0);
      step("R3", 1, 32'h0000_2000, 16'h8BFE, 1, 0, 0);
      step("R2", 1, 32'h0000_2002, NOP, 0, 0, 0);
      // R4 delayed conditional taken, R11 slot
      step("R4", 1, 32'h0000_3000, 16'h8D10, 1, 0, 0);
      step("R11", 1, 32'h0000_3002, NOP, 0, 0, 0);
      step("R4", 1, 32'h0000_3400, 16'h8F80, 0, 0, 0);
      step("R11", 1, 32'h0000_3402, 16'h6013, 0, 0, 0);
      step("R3", 1, 32'h0000_3500, 16'h8F10, 1, 0, 0);
      step("R3", 1, 32'h0000_3502, NOP, 1, 0, 0);
      // R5 / R6 twelve-bit forms
      step("R5", 1, 32'h0001_0000, 16'hA800, 0, 0, 0);
      step("R5", 1, 32'h0001_0002, NOP, 0, 0, 0);
      step("R6", 1, 32'h0001_4000, 16'hB123, 0, 0, 0);
      step("R6", 1, 32'h0001_4002, NOP, 0, 0, 0);
      // R7 register-relative
      step("R7", 1, 32'h0002_0000, 16'h0323, 0, 32'h40, 0);
      step("R7", 1, 32'h0002_0002, NOP, 0, 0, 0);
      step("R7", 1, 32'h0002_1000, 16'h0503, 0, 32'hFFFF_FF00, 0);
      step("R7", 1, 32'h0002_1002, NOP, 0, 0, 0);
      // R8 absolute and return
      step("R8", 1, 32'h0003_0000, 16'h412B, 0, 32'h8000, 0);
      step("R8", 1, 32'h0003_0002, NOP, 0, 0, 0);
      step("R8", 1, 32'h0003_1000, 16'h430B, 0, 32'h9000, 0);
      step("R8", 1, 32'h0003_1002, NOP, 0, 0, 0);
      step("R8", 1, 32'h0003_2000, 16'h000B, 0, 0, 32'h2468);
      step("R8", 1, 32'h0003_2002, NOP, 0, 0, 32'h2468);
      // R9 transfers in a slot
      step("R9", 1, 32'h0004_0000, 16'hA010, 0, 0, 0);
      step("R9", 1, 32'h0004_0002, 16'hB050, 0, 0, 0);
      step("R9", 1, 32'h0004_0024, NOP, 0, 0, 0);
      step("R9", 1, 32'h0004_1000, 16'h430B, 0, 32'h7000, 0);
      step("R9", 1, 32'h0004_1002, 16'h8905, 1, 0, 0);
      step("R9", 1, 32'h0000_7000, NOP, 0, 0, 0);
      // R10 idle gaps keep a slot pending
      step("R10", 1, 32'h0005_0000, 16'hA020, 0, 0, 0);
      step("R10", 0, 32'h0005_0002, 16'hB000, 0, 0, 0);
      step("R10", 0, 32'h0005_0002, 16'h000B, 0, 0, 0);
      step("R10", 1, 32'h0005_0002, NOP, 0, 0, 0);
      step("R10", 1, 32'h0005_0044, NOP, 0, 0, 0);
      // mixed stream
      for (int i = 0; i < 3000; i++) begin
         logic [15:0] w;
         logic [31:0] r;
         r = $urandom;
         unique case (r[3:0])
            4'd0: w = {8'h89, r[15:8]};
            4'd1: w = {8'h8B, r[15:8]};
            4'd2: w = {8'h8D, r[15:8]};
            4'd3: w = {8'h8F, r[15:8]};
            4'd4: w = {4'hA, r[19:8]};
            4'd5: w = {4'hB, r[19:8]};
            4'd6: w = {4'h0, r[11:8], 8'h23};
            4'd7: w = {4'h0, r[11:8], 8'h03};
            4'd8: w = {4'h4, r[11:8], 8'h2B};
            4'd9: w = {4'h4, r[11:8], 8'h0B};
            4'd10: w = 16'h000B;
            default: w = r[31:16];
         endcase
         step("mix", r[4] | r[5], {$urandom} & 32'hFFFF_FFFE, w, r[6],
              $urandom, $urandom);
      end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule